// File: doc/BRIEF.md
# Shader Wave Trap Entry Controller

This block runs beside one wave of a SIMD shader core. At each instruction boundary it decides whether the wave must leave its program and enter an installed trap handler. Several things can cause a trap:

- a trap instruction carrying an immediate code;
- an exception whose enable bit is set;
- a trap request from the host;
- single-step mode;
- optional traps when the wave begins and when it ends.

A per-wave trap-enable bit gates all of these causes. A memory violation that cannot be trapped kills the wave instead.

When a trap is taken, the block does four things:

- sets the wave's privilege flag;
- saves the return PC;
- records the cause;
- redirects the program counter to a handler base address supplied by the host.

While the flag is set, the handler may write a bank of temporary scalar registers and may write the protected status fields: the condition code and the trap-enable bit. The temporary bank is usable only if it was reserved when the wave was launched. A return-from-trap input restores the saved PC and drops the privilege flag.

Top module: `wave_trap_ctrl`

## Requirements
- R1: While reset is held low at a clock edge, the block returns to these values: privilege 0, trap enable 0, condition code 0, cause 0, trap code 0, return PC 0, no PC load, no kill, no trap pulse, nothing pending, bank not reserved, and every temporary register 0.
- R2: A launch pulse does the following, and overrides every other input in that cycle:
  - loads trap enable from the launch trap-enable input;
  - loads the reservation flag from the launch reservation input;
  - clears the temporary registers, privilege, condition code, cause and the pending host request.
- R3: Causes are sampled only in a boundary cycle, that is, a cycle with instruction done, wave begin or wave end. An exception raises a trap only if its raise bit and its unmask bit (1 = enabled) are both set. A masked exception has no effect.
- R4: When several causes are present together, exactly one is taken. The priority order and the codes latched into the cause output are: 1 memory violation, 2 exception, 3 host request, 4 trap instruction, 5 single-step, 6 wave begin, 7 wave end. The trap code output is reloaded from the trap immediate only when cause 4 is taken.
- R5: A trap can be taken only when trap enable is 1 and privilege is 0. In the edge that takes it, the block:
  - sets privilege to 1;
  - pulses trap-taken and the PC load for one cycle, with the load address equal to the handler base;
  - saves the next-PC input as the return PC.
- R6: A memory violation in an instruction-done cycle behaves as follows:
  - if trap enable is 0 or privilege is 1, it pulses wave-kill for one cycle and no trap is taken;
  - in those same states, every other cause is a no-op.
- R7: A host request is held pending until the next boundary. At that boundary the pending request is cleared, whether it was taken, blocked by the gate, or lost to a higher-priority cause. A request that arrives in the boundary cycle itself counts for that boundary.
- R8: A write to a temporary register (there are 16, each with its own index) takes effect only if privilege is 1 and the bank was reserved at launch. Otherwise the write is dropped. The read port returns the addressed register combinationally.
- R9: A status write with select 0 sets the condition code, and with select 1 sets trap enable. It takes effect only while privilege is 1 and is ignored otherwise.
- R10: A return pulse while privilege is 1 does three things:
  - clears privilege;
  - pulses the PC load with the saved return PC;
  - blocks any trap at the same boundary.
- R11: A return pulse while privilege is 0 is ignored.
- R12: With single-step on, every instruction-done cycle outside the handler traps. Instruction-done cycles inside the handler do not trap, so stepping resumes after a return. Wave begin or wave end trap only when their configuration bits are set.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| wave_launch | input | 1 | Wave launch pulse |
| launch_trap_en | input | 1 | Initial trap enable taken at launch |
| launch_ttmp_rsv | input | 1 | Reserve temporary register bank at launch |
| inst_done | input | 1 | An instruction completed this cycle |
| next_pc | input | PC_W | PC to resume at after this boundary |
| wave_begin | input | 1 | Wave about to run its first instruction |
| wave_end | input | 1 | Wave finishing |
| begin_trap_cfg | input | 1 | Trap at wave begin enabled |
| end_trap_cfg | input | 1 | Trap at wave end enabled |
| trap_inst | input | 1 | Completed instruction is a trap instruction |
| trap_imm | input | ID_W | Immediate code of the trap instruction |
| exc_raise | input | NEXC | Exceptions raised by the completed instruction |
| exc_unmask | input | NEXC | Per-exception enable, 1 = may trap |
| mem_viol | input | 1 | Completed instruction hit a memory violation |
| host_trap_req | input | 1 | Host trap request pulse |
| step_en | input | 1 | Single-step / trap-after-instruction mode |
| handler_base | input | PC_W | Handler entry address |
| trap_ret | input | 1 | Return-from-trap pulse |
| ttmp_wr_en | input | 1 | Temporary register write strobe |
| ttmp_wr_idx | input | TIW | Temporary register write index |
| ttmp_wr_data | input | TTMP_W | Temporary register write data |
| ttmp_rd_idx | input | TIW | Temporary register read index |
| stat_wr_en | input | 1 | Protected status write strobe |
| stat_wr_sel | input | 1 | 0 = condition code, 1 = trap enable |
| stat_wr_val | input | 1 | Value for the selected status field |
| pc_load | output | 1 | One-cycle PC redirect |
| pc_load_addr | output | PC_W | Redirect target |
| trap_taken | output | 1 | One-cycle trap entry pulse |
| trap_cause | output | 3 | Code of the last taken cause |
| trap_id | output | ID_W | Immediate of the last trap instruction taken |
| trap_ret_pc | output | PC_W | Saved return PC |
| priv | output | 1 | Privilege flag |
| trap_en | output | 1 | Trap enable status |
| scc | output | 1 | Scalar condition code status |
| wave_kill | output | 1 | One-cycle wave kill |
| host_trap_pending | output | 1 | Host request waiting for a boundary |
| ttmp_reserved | output | 1 | Temporary bank reserved for this wave |
| ttmp_rd_data | output | TTMP_W | Temporary register read data |

## Verification
The bench builds the block with 16-bit PCs and temporary registers, 16 temporary registers and three exception lines. With these values every register of the bank can be written and read back through the port, and distinct PC and handler values stay easy to tell apart. A behavioural model follows every input each cycle. The directed sequences cover:

- all causes stacked at once, then removed one by one from the top of the priority order;
- a host request left waiting across idle cycles;
- boundaries reached while the gate is closed;
- a return and a boundary in the same cycle under single-step;
- writes to the bank on a wave launched without reservation.

// File: rtl/wave_trap_pkg.sv
// Package: shared cause codes and status selects for the wave trap controller.
// Assumes: cause codes double as priority rank (lower code wins).
package wave_trap_pkg;

    typedef enum logic [2:0] {
        CAUSE_NONE     = 3'd0,
        CAUSE_MEMVIOL  = 3'd1,
        CAUSE_EXC      = 3'd2,
        CAUSE_HOST     = 3'd3,
        CAUSE_TRAPINST = 3'd4,
        CAUSE_STEP     = 3'd5,
        CAUSE_BEGIN    = 3'd6,
        CAUSE_END      = 3'd7
    } trap_cause_e;

    localparam int NUM_CAUSES = 7;

    localparam logic STAT_SEL_SCC = 1'b0;
    localparam logic STAT_SEL_TEN = 1'b1;

endpackage

// File: rtl/trap_cause_arb.sv
// Module: fixed-priority selector over trap cause requests.
// Does: returns whether any request is present and the code (index + 1)
//       of the lowest-index request, which is the highest priority.
// Assumes: req[0] is the most urgent cause; purely combinational.
module trap_cause_arb #(
    parameter int N = 7,
    localparam int CW = $clog2(N + 1)
) (
    input  logic [N-1:0]  req,
    output logic          any,
    output logic [CW-1:0] code
);

    // Scan from least to most urgent so the most urgent request writes last.
    always_comb begin
        any  = |req;
        code = '0;
        for (int i = N - 1; i >= 0; i--) begin
            if (req[i]) code = CW'(i + 1);
        end
    end

endmodule

// File: rtl/trap_tmp_bank.sv
// Module: bank of temporary trap scalar registers for one wave.
// Does: one register per entry, written only when the caller grants
//       permission; cleared by reset or a clear pulse; combinational read.
// Assumes: wr_allow already folds in privilege and reservation.
module trap_tmp_bank #(
    parameter int N = 16,
    parameter int W = 32,
    localparam int IW = (N > 1) ? $clog2(N) : 1
) (
    input  logic          clk,
    input  logic          rst_n,
    input  logic          clear,
    input  logic          wr_allow,
    input  logic          wr_en,
    input  logic [IW-1:0] wr_idx,
    input  logic [W-1:0]  wr_data,
    input  logic [IW-1:0] rd_idx,
    output logic [W-1:0]  rd_data
);

    logic [N-1:0][W-1:0] bank;

    for (genvar g = 0; g < N; g++) begin : g_ent
        // Hold one entry: clear on reset or launch, else accept a granted write.
        always_ff @(posedge clk) begin
            if (!rst_n || clear) begin
                bank[g] <= '0;
            end else if (wr_allow && wr_en && (wr_idx == IW'(g))) begin
                bank[g] <= wr_data;
            end
        end
    end

    // Return the addressed entry, zero for an index beyond the bank.
    always_comb begin
        rd_data = '0;
        if (int'(rd_idx) < N) rd_data = bank[rd_idx];
    end

    // R8: a write without permission leaves every entry unchanged.
    assert_drop_unpermitted_R8: assert property (@(posedge clk) disable iff (!rst_n)
        (wr_en && !wr_allow && !clear) |=> $stable(bank));

endmodule

// File: rtl/wave_trap_ctrl.sv
// Module: trap entry controller for one shader wave.
// Does: samples trap causes at boundaries, gates them with trap enable and
//       privilege, redirects the PC to the handler and back, kills the wave
//       on an untrappable memory violation, and guards privileged state.
// Assumes: input pulses last one cycle; all outputs update at the clock edge
//          that samples their cause.
module wave_trap_ctrl
    import wave_trap_pkg::*;
#(
    parameter int PC_W   = 32,
    parameter int TTMP_N = 16,
    parameter int TTMP_W = 32,
    parameter int NEXC   = 4,
    parameter int ID_W   = 8,
    localparam int TIW   = (TTMP_N > 1) ? $clog2(TTMP_N) : 1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wave_launch,
    input  logic              launch_trap_en,
    input  logic              launch_ttmp_rsv,
    input  logic              inst_done,
    input  logic [PC_W-1:0]   next_pc,
    input  logic              wave_begin,
    input  logic              wave_end,
    input  logic              begin_trap_cfg,
    input  logic              end_trap_cfg,
    input  logic              trap_inst,
    input  logic [ID_W-1:0]   trap_imm,
    input  logic [NEXC-1:0]   exc_raise,
    input  logic [NEXC-1:0]   exc_unmask,
    input  logic              mem_viol,
    input  logic              host_trap_req,
    input  logic              step_en,
    input  logic [PC_W-1:0]   handler_base,
    input  logic              trap_ret,
    input  logic              ttmp_wr_en,
    input  logic [TIW-1:0]    ttmp_wr_idx,
    input  logic [TTMP_W-1:0] ttmp_wr_data,
    input  logic [TIW-1:0]    ttmp_rd_idx,
    input  logic              stat_wr_en,
    input  logic              stat_wr_sel,
    input  logic              stat_wr_val,
    output logic              pc_load,
    output logic [PC_W-1:0]   pc_load_addr,
    output logic              trap_taken,
    output logic [2:0]        trap_cause,
    output logic [ID_W-1:0]   trap_id,
    output logic [PC_W-1:0]   trap_ret_pc,
    output logic              priv,
    output logic              trap_en,
    output logic              scc,
    output logic              wave_kill,
    output logic              host_trap_pending,
    output logic              ttmp_reserved,
    output logic [TTMP_W-1:0] ttmp_rd_data
);

    localparam int CW = $clog2(NUM_CAUSES + 1);

    logic                  boundary;
    logic                  host_seen;
    logic [NUM_CAUSES-1:0] cause_req;
    logic                  cause_any;
    logic [CW-1:0]         cause_code;
    logic                  gate_open;
    logic                  take;
    logic                  kill_c;
    logic                  ret_ok;
    logic                  past_valid;
    trap_cause_e           cause_q;

    // Collect cause requests in priority order, index 0 most urgent.
    always_comb begin
        boundary     = inst_done | wave_begin | wave_end;
        host_seen    = host_trap_pending | host_trap_req;
        cause_req[0] = inst_done & mem_viol;
        cause_req[1] = inst_done & (|(exc_raise & exc_unmask));
        cause_req[2] = boundary & host_seen;
        cause_req[3] = inst_done & trap_inst;
        cause_req[4] = inst_done & step_en;
        cause_req[5] = wave_begin & begin_trap_cfg;
        cause_req[6] = wave_end & end_trap_cfg;
    end

    trap_cause_arb #(.N(NUM_CAUSES)) u_arb (
        .req  (cause_req),
        .any  (cause_any),
        .code (cause_code)
    );

    // Decide entry, kill and return for this cycle.
    always_comb begin
        gate_open = trap_en & ~priv;
        take      = ~wave_launch & cause_any & gate_open;
        kill_c    = ~wave_launch & cause_req[0] & ~gate_open;
        ret_ok    = ~wave_launch & trap_ret & priv;
    end

    // Sequence privilege, redirect, cause capture and protected status fields.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            priv          <= 1'b0;
            trap_en       <= 1'b0;
            scc           <= 1'b0;
            ttmp_reserved <= 1'b0;
            cause_q       <= CAUSE_NONE;
            trap_id       <= '0;
            trap_ret_pc   <= '0;
            pc_load       <= 1'b0;
            pc_load_addr  <= '0;
            trap_taken    <= 1'b0;
            wave_kill     <= 1'b0;
        end else begin
            pc_load    <= 1'b0;
            trap_taken <= 1'b0;
            wave_kill  <= kill_c;
            if (wave_launch) begin
                priv          <= 1'b0;
                trap_en       <= launch_trap_en;
                scc           <= 1'b0;
                ttmp_reserved <= launch_ttmp_rsv;
                cause_q       <= CAUSE_NONE;
            end else begin
                if (take) begin
                    priv         <= 1'b1;
                    trap_taken   <= 1'b1;
                    cause_q      <= trap_cause_e'(cause_code);
                    trap_ret_pc  <= next_pc;
                    pc_load      <= 1'b1;
                    pc_load_addr <= handler_base;
                    if (trap_cause_e'(cause_code) == CAUSE_TRAPINST) trap_id <= trap_imm;
                end else if (ret_ok) begin
                    priv         <= 1'b0;
                    pc_load      <= 1'b1;
                    pc_load_addr <= trap_ret_pc;
                end
                if (stat_wr_en && priv) begin
                    if (stat_wr_sel == STAT_SEL_SCC) scc <= stat_wr_val;
                    else                             trap_en <= stat_wr_val;
                end
            end
        end
    end

    // Hold a host request until the next boundary consumes it.
    always_ff @(posedge clk) begin
        if (!rst_n || wave_launch || boundary) host_trap_pending <= 1'b0;
        else if (host_trap_req)                host_trap_pending <= 1'b1;
    end

    // Mark that at least one cycle has run out of reset, for history checks.
    always_ff @(posedge clk) begin
        past_valid <= rst_n;
    end

    assign trap_cause = cause_q;

    trap_tmp_bank #(.N(TTMP_N), .W(TTMP_W)) u_bank (
        .clk      (clk),
        .rst_n    (rst_n),
        .clear    (wave_launch),
        .wr_allow (priv & ttmp_reserved),
        .wr_en    (ttmp_wr_en),
        .wr_idx   (ttmp_wr_idx),
        .wr_data  (ttmp_wr_data),
        .rd_idx   (ttmp_rd_idx),
        .rd_data  (ttmp_rd_data)
    );

    // R5/R6: entry only from an open gate.
    assert_entry_gated_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> ($past(trap_en) && !$past(priv)));

    // R5: entry raises privilege, saves PC and jumps to the handler base.
    assert_entry_redirect_R5: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (priv && pc_load && pc_load_addr == $past(handler_base)
                        && trap_ret_pc == $past(next_pc)));

    // R4: a taken trap always records a real cause.
    assert_cause_recorded_R4: assert property (@(posedge clk) disable iff (!rst_n)
        trap_taken |-> (trap_cause != 3'd0));

    // R6: a kill follows a memory violation and never coincides with entry.
    assert_kill_source_R6: assert property (@(posedge clk) disable iff (!rst_n)
        wave_kill |-> ($past(mem_viol) && !trap_taken));

    // R7: nothing stays pending after a boundary.
    assert_host_consumed_R7: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(boundary)) |-> !host_trap_pending);

    // R10: a privileged return restores the saved PC and drops privilege.
    assert_return_restores_R10: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(trap_ret && priv && !wave_launch))
            |-> (!priv && pc_load && pc_load_addr == $past(trap_ret_pc)));

    // R9: the condition code cannot move outside the handler.
    assert_status_locked_R9: assert property (@(posedge clk) disable iff (!rst_n)
        (past_valid && $past(!priv && !wave_launch)) |-> $stable(scc));

endmodule

// File: tb/wave_trap_ctrl_bench.sv
`timescale 1ns/1ps
module wave_trap_ctrl_bench;

    localparam int PC_W = 16, TTMP_N = 16, TTMP_W = 16, NEXC = 3, ID_W = 8;
    localparam int TIW = 4;

    logic clk = 1'b0;
    logic rst_n = 1'b0;
    always #10 clk = ~clk;

    logic              wave_launch, launch_trap_en, launch_ttmp_rsv;
    logic              inst_done, wave_begin, wave_end, begin_trap_cfg, end_trap_cfg;
    logic [PC_W-1:0]   next_pc, handler_base;
    logic              trap_inst;
    logic [ID_W-1:0]   trap_imm;
    logic [NEXC-1:0]   exc_raise, exc_unmask;
    logic              mem_viol, host_trap_req, step_en, trap_ret;
    logic              ttmp_wr_en;
    logic [TIW-1:0]    ttmp_wr_idx, ttmp_rd_idx;
    logic [TTMP_W-1:0] ttmp_wr_data;
    logic              stat_wr_en, stat_wr_sel, stat_wr_val;

    logic              pc_load, trap_taken, priv, trap_en, scc, wave_kill;
    logic              host_trap_pending, ttmp_reserved;
    logic [PC_W-1:0]   pc_load_addr, trap_ret_pc;
    logic [2:0]        trap_cause;
    logic [ID_W-1:0]   trap_id;
    logic [TTMP_W-1:0] ttmp_rd_data;

    wave_trap_ctrl #(.PC_W(PC_W), .TTMP_N(TTMP_N), .TTMP_W(TTMP_W),
                     .NEXC(NEXC), .ID_W(ID_W)) u_wave_trap_ctrl (.*);

    int tests = 0, fails = 0;
    string cur_req = "R1";

    // Reference model state.
    int m_priv, m_ten, m_scc, m_rsv, m_cause, m_id, m_retpc, m_pcl, m_addr;
    int m_taken, m_kill, m_pend;
    int m_tt [TTMP_N];

    always @(posedge clk) begin
        int bnd, hs, c, open, p0;
        if (!rst_n) begin
            m_priv = 0; m_ten = 0; m_scc = 0; m_rsv = 0; m_cause = 0; m_id = 0;
            m_retpc = 0; m_pcl = 0; m_addr = 0; m_taken = 0; m_kill = 0; m_pend = 0;
            foreach (m_tt[i]) m_tt[i] = 0;
        end else begin
            bnd = int'(inst_done | wave_begin | wave_end);
            hs  = (m_pend != 0 || host_trap_req) ? 1 : 0;
            c = 0;
            if (inst_done && mem_viol)                        c = 1;
            else if (inst_done && ((exc_raise & exc_unmask) != 0)) c = 2;
            else if (bnd != 0 && hs != 0)                     c = 3;
            else if (inst_done && trap_inst)                  c = 4;
            else if (inst_done && step_en)                    c = 5;
            else if (wave_begin && begin_trap_cfg)            c = 6;
            else if (wave_end && end_trap_cfg)                c = 7;
            open = (m_ten != 0 && m_priv == 0) ? 1 : 0;
            p0 = m_priv;
            m_pcl = 0; m_taken = 0; m_kill = 0;
            if (wave_launch) begin
                m_priv = 0; m_ten = int'(launch_trap_en); m_scc = 0;
                m_rsv = int'(launch_ttmp_rsv); m_cause = 0; m_pend = 0;
                foreach (m_tt[i]) m_tt[i] = 0;
            end else begin
                m_kill = (inst_done && mem_viol && open == 0) ? 1 : 0;
                if (c != 0 && open != 0) begin
                    m_priv = 1; m_taken = 1; m_cause = c; m_retpc = int'(next_pc);
                    m_pcl = 1; m_addr = int'(handler_base);
                    if (c == 4) m_id = int'(trap_imm);
                end else if (trap_ret && p0 != 0) begin
                    m_priv = 0; m_pcl = 1; m_addr = m_retpc;
                end
                if (stat_wr_en && p0 != 0) begin
                    if (stat_wr_sel) m_ten = int'(stat_wr_val);
                    else             m_scc = int'(stat_wr_val);
                end
                if (ttmp_wr_en && p0 != 0 && m_rsv != 0) m_tt[ttmp_wr_idx] = int'(ttmp_wr_data);
                if (bnd != 0)          m_pend = 0;
                else if (host_trap_req) m_pend = 1;
            end
        end
    end

    task automatic chk(string sig, int act, int exp);
        tests++;
        if (act != exp) begin
            fails++;
            $display("FAIL %s %s actual=%0d expected=%0d at %0t", cur_req, sig, act, exp, $time);
        end
    endtask

    task automatic compare_all();
        chk("priv", int'(priv), m_priv);
        chk("trap_en", int'(trap_en), m_ten);
        chk("scc", int'(scc), m_scc);
        chk("reserved", int'(ttmp_reserved), m_rsv);
        chk("cause", int'(trap_cause), m_cause);
        chk("trap_id", int'(trap_id), m_id);
        chk("ret_pc", int'(trap_ret_pc), m_retpc);
        chk("pc_load", int'(pc_load), m_pcl);
        if (m_pcl != 0) chk("pc_load_addr", int'(pc_load_addr), m_addr);
        chk("trap_taken", int'(trap_taken), m_taken);
        chk("wave_kill", int'(wave_kill), m_kill);
        chk("pending", int'(host_trap_pending), m_pend);
        chk("ttmp_rd", int'(ttmp_rd_data), m_tt[ttmp_rd_idx]);
    endtask

    task automatic cyc();
        @(posedge clk);
        @(negedge clk);
        compare_all();
    endtask

    task automatic idle();
        wave_launch = 0; inst_done = 0; wave_begin = 0; wave_end = 0;
        trap_inst = 0; exc_raise = '0; mem_viol = 0; host_trap_req = 0;
        trap_ret = 0; ttmp_wr_en = 0; stat_wr_en = 0;
    endtask

    task automatic launch(logic ten, logic rsv);
        idle(); wave_launch = 1; launch_trap_en = ten; launch_ttmp_rsv = rsv;
        cyc(); idle();
    endtask

    task automatic done(logic [PC_W-1:0] pc);
        inst_done = 1; next_pc = pc; cyc(); idle();
    endtask

    task automatic ret();
        trap_ret = 1; cyc(); idle();
    endtask

    task automatic summary();
        $display("[TB] %0d tests run, %0d failed", tests, fails);
        $finish;
    endtask

    initial begin
        repeat (100000) @(posedge clk);
        fails++;
        $display("FAIL watchdog expired");
        summary();
    end

    initial begin
        idle();
        launch_trap_en = 0; launch_ttmp_rsv = 0; begin_trap_cfg = 0; end_trap_cfg = 0;
        next_pc = '0; handler_base = 16'h8000; trap_imm = '0; exc_unmask = '0;
        step_en = 0; ttmp_wr_idx = '0; ttmp_rd_idx = '0; ttmp_wr_data = '0;
        stat_wr_sel = 0; stat_wr_val = 0;

        // R1: reset state
        cur_req = "R1";
        cyc(); cyc();
        rst_n = 1;
        cyc();

        // R2: launch without reservation, trap disabled
        cur_req = "R2";
        launch(0, 0);

        // R6: gate closed: trap instruction is a no-op, memory violation kills
        cur_req = "R6";
        trap_inst = 1; trap_imm = 8'h11; done(16'h0010);
        mem_viol = 1; done(16'h0014);

        // R2: relaunch with trap enable and reserved bank
        cur_req = "R2";
        launch(1, 1);

        // R8: bank write outside the handler is dropped
        cur_req = "R8";
        ttmp_wr_en = 1; ttmp_wr_idx = 4'd3; ttmp_wr_data = 16'hBEEF; ttmp_rd_idx = 4'd3;
        cyc(); idle(); cyc();

        // R9: status write outside the handler is ignored
        cur_req = "R9";
        stat_wr_en = 1; stat_wr_sel = 0; stat_wr_val = 1; cyc(); idle(); cyc();

        // R11: return outside the handler is ignored
        cur_req = "R11";
        ret();

        // R3: masked exception does nothing, wave begin without config does nothing
        cur_req = "R3";
        exc_raise = 3'b010; exc_unmask = 3'b101; done(16'h0020);
        wave_begin = 1; next_pc = 16'h0100; cyc(); idle();
        exc_raise = 3'b010; cyc(); idle();

        // R3 R5: unmasked exception enters the handler
        exc_raise = 3'b100; handler_base = 16'h9A00; done(16'h0024);

        // R8 R9: privileged writes land
        cur_req = "R8";
        for (int i = 0; i < TTMP_N; i++) begin
            ttmp_wr_en = 1; ttmp_wr_idx = TIW'(i); ttmp_wr_data = TTMP_W'(16'h1000 + i * 7);
            ttmp_rd_idx = TIW'(i); cyc();
        end
        idle();
        ttmp_rd_idx = 4'd15; cyc();
        cur_req = "R9";
        stat_wr_en = 1; stat_wr_sel = 0; stat_wr_val = 1; cyc(); idle();

        // R6: memory violation inside the handler kills
        cur_req = "R6";
        mem_viol = 1; done(16'h9A04);

        // R10: return restores PC
        cur_req = "R10";
        ret();
        cur_req = "R8";
        ttmp_wr_en = 1; ttmp_wr_idx = 4'd15; ttmp_wr_data = 16'h0BAD; ttmp_rd_idx = 4'd15;
        cyc(); idle();

        // R4: priority walk, one cause removed per step
        cur_req = "R4";
        mem_viol = 1; exc_raise = 3'b001; host_trap_req = 1; trap_inst = 1;
        trap_imm = 8'h22; step_en = 1; done(16'h0200); ret(); step_en = 0;
        exc_raise = 3'b001; host_trap_req = 1; trap_inst = 1; trap_imm = 8'h33;
        step_en = 1; done(16'h0204); ret(); step_en = 0;
        host_trap_req = 1; trap_inst = 1; trap_imm = 8'h44; step_en = 1;
        done(16'h0208); ret(); step_en = 0;
        trap_inst = 1; trap_imm = 8'h55; step_en = 1; done(16'h020C); ret();
        step_en = 0;
        cur_req = "R12";
        step_en = 1; done(16'h0210); ret(); step_en = 0;
        begin_trap_cfg = 1; wave_begin = 1; next_pc = 16'h0300; cyc(); idle(); ret();
        end_trap_cfg = 1; wave_end = 1; next_pc = 16'h0304; cyc(); idle(); ret();
        wave_begin = 1; wave_end = 1; next_pc = 16'h0308; cyc(); idle(); ret();
        begin_trap_cfg = 0; end_trap_cfg = 0;

        // R12: single-step re-arms after return; no trap inside the handler
        cur_req = "R12";
        step_en = 1;
        done(16'h0400);
        done(16'h0404);
        cur_req = "R10";
        trap_ret = 1; inst_done = 1; next_pc = 16'h0408; cyc(); idle();
        cur_req = "R12";
        done(16'h040C);
        ret(); step_en = 0;

        // R7: host request waits for a boundary
        cur_req = "R7";
        host_trap_req = 1; cyc(); idle(); cyc(); cyc();
        handler_base = 16'hC000; done(16'h0500); ret();
        host_trap_req = 1; cyc(); idle();
        exc_raise = 3'b001; done(16'h0504); ret();
        cyc();
        host_trap_req = 1; cyc(); idle();
        wave_end = 1; next_pc = 16'h0508; cyc(); idle();
        host_trap_req = 1; done(16'h050C);
        host_trap_req = 1; cyc(); idle(); done(16'h0510);
        cur_req = "R9";
        stat_wr_en = 1; stat_wr_sel = 1; stat_wr_val = 0; cyc(); idle();
        cur_req = "R7";
        host_trap_req = 1; cyc(); idle();
        ret();
        done(16'h0514);
        cur_req = "R6";
        mem_viol = 1; trap_inst = 1; done(16'h0518);

        // R8: privileged write to an unreserved bank is dropped
        cur_req = "R8";
        launch(1, 0);
        trap_inst = 1; trap_imm = 8'h66; done(16'h0600);
        ttmp_wr_en = 1; ttmp_wr_idx = 4'd7; ttmp_wr_data = 16'h7777; ttmp_rd_idx = 4'd7;
        cyc(); idle(); cyc();

        // R2: launch while privileged clears privilege
        cur_req = "R2";
        launch(1, 1);
        cyc();

        // R1: reset mid-run returns to the reset state
        cur_req = "R1";
        trap_inst = 1; done(16'h0700);
        rst_n = 0; cyc(); cyc(); rst_n = 1; cyc();

        summary();
    end

endmodule